// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple register bus with address, write enable, write data and read data. Software arms it by setting an enable bit and a 4-bit interval code in one register. The countdown runs in half-second steps, and each step is produced by an internal clock divider whose length is a parameter. Software keeps the system alive by writing a reload word that carries a 12-bit key. A write that does not carry both the key and the reload bit changes nothing.

If the count runs out while system reset is the selected expiry action, the block raises a reset-request output for a fixed number of cycles. The count then stays at zero until software reloads the timer or disables it. Interval codes map onto a non-linear table that runs from half a second up to sixteen seconds. A new interval written while the timer runs takes effect at the next keyed reload.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the reload, action and mode registers all read 0 and `rst_req` is low.
- R2: The action register (offset 0x14) reads back bits 1:0 as written. The mode register (offset 0x18) reads back the enable at bit 0 and the interval code at bits IVL_SHIFT+3:IVL_SHIFT (default 7:4). All other bits, and the whole reload register (offset 0x10), read 0.
- R3: A write to offset 0x10 whose bit 0 is 1 and whose bits 12:1 equal 0xA57 (data 0x14AF) restarts the count from the full current interval, measured from that write's clock edge.
- R4: A write to offset 0x10 with a wrong key or with bit 0 clear has no effect, and the expiry time stays unchanged.
- R5: Interval code c gives a timeout of H(c) half-second ticks, where each tick is TICK_DIV clock cycles: H(0)=1; H(c)=2c for c=1..6; H(7..11)=16, 20, 24, 28, 32; H(12..15)=32.
- R6: A mode write with bit 0 set, made while the timer is disabled, starts the count from the written code. With action 01, `rst_req` rises exactly H(c)*TICK_DIV cycles after that write's edge and stays high for RST_PULSE cycles.
- R7: With any action value other than 01, expiry never raises `rst_req`.
- R8: After expiry the count holds, and no further request appears until a keyed reload. A keyed reload restarts a full interval.
- R9: A mode write with bit 0 clear stops the timer. `rst_req` drops at that write's edge, and no request appears while the timer is disabled.
- R10: Rewriting the interval code while the timer runs does not change the running count. The next keyed reload counts from the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rst_req | output | 1 | System reset request pulse |

## Verification
The expiry path is driven with random interval codes paired with random action values. This separates the interval decode from the action gate: an error in the decode shows up as a wrong rise time, and an error in the gate shows up as a request that appears or is missing. Directed sequences then compare a correct key against near-miss keys and against a cleared reload bit in the middle of a count, which shows whether the key check itself causes any side effect. Further sequences change the code without a reload and then with one, and disable the timer both mid-count and mid-pulse, which tells a deferred interval change apart from an immediate one. Random write data to the action and mode registers shows which bits are stored and which read as zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int          CNT_W       = 6;
    localparam int          CTRL_OFS    = 'h10;
    localparam int          ACT_OFS     = 'h14;
    localparam int          MODE_OFS    = 'h18;
    localparam logic [11:0] RELOAD_KEY  = 12'hA57;
    localparam logic [1:0]  ACT_SYS_RST = 2'b01;

    typedef struct packed {
        logic       en;
        logic [3:0] code;
        logic [1:0] act;
    } wdt_state_t;

    // Timeout length in half-second ticks for a 4-bit interval code.
    function automatic logic [CNT_W-1:0] ivl_half_ticks(input logic [3:0] code);
        logic [CNT_W-1:0] r;
        if (code == 4'd0)
            r = CNT_W'(1);
        else if (code <= 4'd6)
            r = CNT_W'({code, 1'b0});
        else if (code <= 4'd11)
            r = CNT_W'(({2'b00, code} << 2) - 6'd12);
        else
            r = CNT_W'(32);
        return r;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IVL_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              en,
    output logic [1:0]        act,
    output logic              load,
    output logic [3:0]        load_code,
    output logic              stop
);
    wdt_state_t st_d, st_q;

    logic hit_ctrl, hit_act, hit_mode, key_ok;

    wire unused_wbits = ^{wdata[31:13], wdata[IVL_SHIFT-1:1]};

    always_comb begin
        hit_ctrl = (addr == ADDR_W'(CTRL_OFS));
        hit_act  = (addr == ADDR_W'(ACT_OFS));
        hit_mode = (addr == ADDR_W'(MODE_OFS));
        key_ok   = wdata[0] && (wdata[12:1] == RELOAD_KEY);

        st_d = st_q;
        if (wr_en && hit_act)
            st_d.act = wdata[1:0];
        if (wr_en && hit_mode) begin
            st_d.en   = wdata[0];
            st_d.code = wdata[IVL_SHIFT +: 4];
        end

        load      = (wr_en && hit_ctrl && key_ok) ||
                    (wr_en && hit_mode && wdata[0] && !st_q.en);
        load_code = (wr_en && hit_mode) ? wdata[IVL_SHIFT +: 4] : st_q.code;
        stop      = wr_en && hit_mode && !wdata[0];

        rdata = '0;
        if (hit_act)
            rdata[1:0] = st_q.act;
        else if (hit_mode) begin
            rdata[0]             = st_q.en;
            rdata[IVL_SHIFT +: 4] = st_q.code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign en  = st_q.en;
    assign act = st_q.act;
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int TICK_DIV = 12_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick = run && !restart && (div_q == LAST);
        if (!run || restart || div_q == LAST)
            div_d = '0;
        else
            div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else
            div_q <= div_d;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int RST_PULSE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       act,
    input  logic             load,
    input  logic [3:0]       load_code,
    input  logic             stop,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req
);
    localparam int PW = $clog2(RST_PULSE + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    pulse;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic expire;

    always_comb begin
        s_d    = s_q;
        expire = en && tick && !load && (s_q.cnt == CNT_W'(1));

        if (load)
            s_d.cnt = ivl_half_ticks(load_code);
        else if (tick && s_q.cnt != '0)
            s_d.cnt = s_q.cnt - 1'b1;

        if (stop || load)
            s_d.pulse = '0;
        else if (expire && act == ACT_SYS_RST)
            s_d.pulse = PW'(RST_PULSE);
        else if (s_q.pulse != '0)
            s_d.pulse = s_q.pulse - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cnt     = s_q.cnt;
    assign rst_req = (s_q.pulse != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int IVL_SHIFT = 4,
    parameter int TICK_DIV  = 12_000_000,
    parameter int RST_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rst_req
);
    logic             en_w, load_w, stop_w, tick_w;
    logic [1:0]       act_w;
    logic [3:0]       lcode_w;
    logic [CNT_W-1:0] cnt_w;

    wdt_regs #(.ADDR_W(ADDR_W), .IVL_SHIFT(IVL_SHIFT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .en(en_w), .act(act_w), .load(load_w),
        .load_code(lcode_w), .stop(stop_w)
    );

    wdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(en_w), .restart(load_w), .tick(tick_w)
    );

    wdt_count #(.RST_PULSE(RST_PULSE)) u_count (
        .clk(clk), .rst_n(rst_n), .en(en_w), .act(act_w), .load(load_w),
        .load_code(lcode_w), .stop(stop_w), .tick(tick_w),
        .cnt(cnt_w), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RST_PULSE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              rst_req,
    input logic              en,
    input logic [1:0]        act,
    input logic              load,
    input logic [CNT_W-1:0]  cnt
);
    int hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= 0;
        else
            hi_q <= rst_req ? hi_q + 1 : 0;
    end

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> hi_q < RST_PULSE);

    // R7
    act_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(act) == ACT_SYS_RST);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !rst_req);

    // R4
    no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt <= $past(cnt));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> cnt == '0);

    // R2
    always @(posedge clk) begin
        if (rst_n && !wr_en && addr == ADDR_W'(CTRL_OFS))
            ctrl_read_chk: assert (rdata == 32'd0);
    end
endmodule

bind keyed_wdt wdt_chk #(.ADDR_W(ADDR_W), .RST_PULSE(RST_PULSE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
    .rst_req(rst_req), .en(en_w), .act(act_w), .load(load_w), .cnt(cnt_w)
);

// File: tb/tb_keyed_wdt.sv
module tb_keyed_wdt;
    localparam int T  = 4;
    localparam int PL = 3;
    localparam logic [7:0] A_CTRL = 8'h10, A_ACT = 8'h14, A_MODE = 8'h18;
    localparam logic [31:0] GOOD_KEY = 32'h0000_14AF;

    logic clk = 0, rst_n = 0, wr_en = 0, rst_req;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    keyed_wdt #(.ADDR_W(8), .IVL_SHIFT(4), .TICK_DIV(T), .RST_PULSE(PL)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int half(input int c);
        case (c)
            0: return 1;   1: return 2;   2: return 4;   3: return 6;
            4: return 8;   5: return 10;  6: return 12;  7: return 16;
            8: return 20;  9: return 24;  10: return 28;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input string req, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0; addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; wr_en = 0; #1 d = rdata;
    endtask

    // returns cyc at first negedge where rst_req is high, or -1
    task automatic wait_rise(input int lim, output int t);
        t = -1;
        for (int i = 0; i < lim; i++) begin
            if (rst_req) begin t = cyc; break; end
            @(negedge clk);
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (rst_req && w < 50) begin w++; @(negedge clk); end
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (rst_req) seen = 1;
            @(negedge clk);
        end
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int t0, t, w, s;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_ACT, d);  chk("R1 act", d, 0);
        rd(A_MODE, d); chk("R1 mode", d, 0);
        chk("R1 rst_req", rst_req, 0);

        // R2 readback with random data
        for (int i = 0; i < 8; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr(A_ACT, r); rd(A_ACT, d); chk("R2 act", d, r & 32'h3);
            r = r & ~32'h1;
            wr(A_MODE, r); rd(A_MODE, d); chk("R2 mode", d, r & 32'hF0);
            wr(A_CTRL, r); rd(A_CTRL, d); chk("R2 ctrl", d, 0);
        end
        wr(A_MODE, 0);

        // R5/R6/R7 random codes and actions
        for (int i = 0; i < 24; i++) begin
            int c, a;
            c = (i < 16) ? i : int'($urandom_range(0, 15));
            a = int'($urandom_range(0, 3));
            if (i < 16) a = (i % 3 == 2) ? int'($urandom_range(2, 3)) : 1;
            wr(A_ACT, a);
            wr(A_MODE, (c << 4) | 1); t0 = cyc;
            if (a == 1) begin
                wait_rise(200, t);
                chk("R5 R6 expiry time", t - t0, half(c) * T);
                pulse_width(w);
                chk("R6 pulse width", w, PL);
            end else begin
                quiet(half(c) * T + 20, s);
                chk("R7 no request", s, 0);
            end
            wr(A_MODE, 0);
        end

        // R4 bad keys mid-count: code 2 -> 16 cycles
        wr(A_ACT, 1);
        wr(A_MODE, 32'h21); t0 = cyc;
        wr(A_CTRL, GOOD_KEY ^ 32'h2);
        wr(A_CTRL, GOOD_KEY & ~32'h1);
        wr(A_CTRL, GOOD_KEY ^ 32'h1000);
        wait_rise(200, t);
        chk("R4 bad key ignored", t - t0, 16);
        pulse_width(w);

        // R8 hold after expiry, then reload restarts
        quiet(150, s); chk("R8 hold after expiry", s, 0);
        wr(A_CTRL, GOOD_KEY); t0 = cyc;
        wait_rise(200, t); chk("R8 reload after expiry", t - t0, 16);
        pulse_width(w);

        // R3 keyed reload mid-count
        wr(A_CTRL, GOOD_KEY);
        repeat (10) @(negedge clk);
        wr(A_CTRL, GOOD_KEY); t0 = cyc;
        wait_rise(200, t); chk("R3 reload restarts", t - t0, 16);
        pulse_width(w);

        // R10 code change deferred until reload
        wr(A_CTRL, GOOD_KEY); t0 = cyc;
        wr(A_MODE, 32'h31);
        wait_rise(200, t); chk("R10 no change before reload", t - t0, 16);
        pulse_width(w);
        wr(A_CTRL, GOOD_KEY); t0 = cyc;
        wait_rise(200, t); chk("R10 new code on reload", t - t0, 24);

        // R9 disable during pulse drops request at once
        wr(A_MODE, 0);
        chk("R9 drop on disable", rst_req, 0);
        // R9 disable mid-count
        wr(A_MODE, 32'h11);
        repeat (3) @(negedge clk);
        wr(A_MODE, 0);
        quiet(120, s); chk("R9 disabled stays quiet", s, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule